// File: doc/BRIEF.md
# Clock Frequency Monitor with Lock

This block checks that a monitored clock runs inside a programmed frequency band. It counts the rising edges of the monitored clock over a fixed window of reference-clock cycles. At the end of each window it compares the count with an upper and a lower bound. When the count is outside that band, it drives a registered reset-request output. The monitored clock crosses into the reference domain as a toggle that passes through a two-flop synchronizer. All counting and comparing happens in the reference domain. For this to work, the monitored clock period must be at least two reference periods.

Software reaches the block through a plain register port that writes on one cycle and reads combinationally. There are four registers:

| Offset | Register | Write | Read |
|--------|----------|-------|------|
| 0x00 | protect | key 0x06 locks the bounds; any other value unlocks | 0x06 while locked, otherwise 0 |
| 0x04 | control | key 0xE4 starts monitoring; any other value stops it | 0xE4 while running, otherwise 0 |
| 0x10 | lower bound | accepted only while unlocked and stopped | always readable |
| 0x20 | upper bound | accepted only while unlocked and stopped | always readable |

Both keys are compared on bits [7:0] of the write data. The port carries no data stream, so it has no valid/ready handshake and never applies back-pressure. Every access completes in the cycle it is presented. The reset request is a level output for the system reset logic.

Top module: `clk_freq_guard`

## Requirements
- R1: After reset, the lower bound reads 0xA5, the upper bound reads 0xC9, protect and control read 0, and the reset request is low.
- R2: The protect, control, lower-bound and upper-bound registers sit at offsets 0x00, 0x04, 0x10 and 0x20. Each bound occupies bits [CNT_W-1:0]. Higher bits are dropped on write and read as zero. Any other offset reads 0.
- R3: Writing 0x06 in bits [7:0] to protect locks the bounds, so later bound writes leave them unchanged. Writing any other value unlocks them, and protect reads 0x06 while locked.
- R4: Writing 0xE4 in bits [7:0] to control starts monitoring, and any other value stops it. Control reads 0xE4 while running. While running, bound writes are ignored.
- R5: Both bounds read back their stored values whatever the protect and control state.
- R6: Each window lasts WIN_LEN reference cycles. The first window starts on the cycle after monitoring is enabled. A monitored edge is counted within three reference cycles of occurring, and the count saturates at 2^CNT_W-1.
- R7: At each window end, the request becomes 1 if count < lower or count > upper, and 0 otherwise. It changes at no other time while running, so a raised request holds for at least one full window.
- R8: If lower ≥ upper, every window end raises the request, even for a count equal to both bounds.
- R9: Stopping monitoring drops the request on the next reference cycle, and it stays low while stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, also clocks the register port |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| mon_clk | input | 1 | Monitored clock |
| wr_en | input | 1 | Write strobe for the register at addr |
| addr | input | ADDR_W | Register offset |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Combinational read data for addr |
| freq_rst_req | output | 1 | Registered reset request, high while the monitored frequency is out of band |

## Verification
The bench builds the block with WIN_LEN = 600 and the default CNT_W = 8. A window that is not a power of two exercises the end-of-window wrap of a counter that does not fill its width. With a 600-cycle window, a monitored clock of two reference periods produces about 300 edges, so 8-bit saturation is reachable. Bounds of 0xF0..0xFF then tell a saturating counter apart from a wrapping one. A monitored clock that is stopped gives a count of exactly zero. This allows the equal-bounds case and the exact cycle of the first window end to be checked without any edge-alignment slack.

// File: rtl/cfm_pkg.sv
package cfm_pkg;
  localparam int CODE_W = 8;
  localparam logic [CODE_W-1:0] LOCK_KEY = 8'h06;
  localparam logic [CODE_W-1:0] RUN_KEY  = 8'hE4;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PROT,
    SEL_CTRL,
    SEL_LO,
    SEL_HI
  } reg_sel_e;
endpackage

// File: rtl/cfm_regs.sv
module cfm_regs
  import cfm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8,
  parameter logic [ADDR_W-1:0] PROT_OFS = 8'h00,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h04,
  parameter logic [ADDR_W-1:0] LO_OFS   = 8'h10,
  parameter logic [ADDR_W-1:0] HI_OFS   = 8'h20,
  parameter logic [CNT_W-1:0]  LO_RST   = 8'hA5,
  parameter logic [CNT_W-1:0]  HI_RST   = 8'hC9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CODE_W-1:0] wr_key,
  input  logic [CNT_W-1:0]  wr_bound,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  lo_bound,
  output logic [CNT_W-1:0]  hi_bound,
  output logic              run
);
  reg_sel_e         sel;
  logic             locked_q;
  logic             run_q;
  logic [CNT_W-1:0] lo_q;
  logic [CNT_W-1:0] hi_q;
  logic             bound_open;

  always_comb begin
    sel = SEL_NONE;
    if (addr == PROT_OFS)      sel = SEL_PROT;
    else if (addr == CTRL_OFS) sel = SEL_CTRL;
    else if (addr == LO_OFS)   sel = SEL_LO;
    else if (addr == HI_OFS)   sel = SEL_HI;
  end

  assign bound_open = !locked_q && !run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      run_q    <= 1'b0;
      lo_q     <= LO_RST;
      hi_q     <= HI_RST;
    end else if (wr_en) begin
      case (sel)
        SEL_PROT: locked_q <= (wr_key == LOCK_KEY);
        SEL_CTRL: run_q    <= (wr_key == RUN_KEY);
        SEL_LO:   if (bound_open) lo_q <= wr_bound;
        SEL_HI:   if (bound_open) hi_q <= wr_bound;
        default:  ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_PROT: rdata[CODE_W-1:0] = locked_q ? LOCK_KEY : '0;
      SEL_CTRL: rdata[CODE_W-1:0] = run_q ? RUN_KEY : '0;
      SEL_LO:   rdata[CNT_W-1:0]  = lo_q;
      SEL_HI:   rdata[CNT_W-1:0]  = hi_q;
      default:  rdata = '0;
    endcase
  end

  assign lo_bound = lo_q;
  assign hi_bound = hi_q;
  assign run      = run_q;

  assert_locked_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && locked_q) |=> ($stable(lo_q) && $stable(hi_q)));

  assert_running_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && run_q) |=> ($stable(lo_q) && $stable(hi_q)));

  assert_flags_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(locked_q) && $stable(run_q)));
endmodule

// File: rtl/cfm_edge_sync.sv
module cfm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic mon_clk,
  input  logic clk,
  input  logic rst_n,
  output logic edge_pulse
);
  logic              tog_q;
  logic [STAGES:0]   shift_q;

  always_ff @(posedge mon_clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= ~tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[STAGES-1:0], tog_q};
  end

  assign edge_pulse = shift_q[STAGES] ^ shift_q[STAGES-1];
endmodule

// File: rtl/cfm_window.sv
module cfm_window #(
  parameter int CNT_W   = 8,
  parameter int WIN_LEN = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             edge_pulse,
  input  logic [CNT_W-1:0] lo_bound,
  input  logic [CNT_W-1:0] hi_bound,
  output logic             req
);
  localparam int WIN_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam logic [WIN_W-1:0] WIN_END  = WIN_W'(WIN_LEN - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = {CNT_W{1'b1}};

  logic [WIN_W-1:0] win_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             req_q;
  logic             at_end;
  logic             out_of_band;

  assign cnt_inc     = (edge_pulse && (cnt_q != CNT_FULL)) ? cnt_q + 1'b1 : cnt_q;
  assign at_end      = (win_q == WIN_END);
  assign out_of_band = (lo_bound >= hi_bound) || (cnt_inc < lo_bound) || (cnt_inc > hi_bound);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      cnt_q <= '0;
      req_q <= 1'b0;
    end else if (!run) begin
      win_q <= '0;
      cnt_q <= '0;
      req_q <= 1'b0;
    end else if (at_end) begin
      win_q <= '0;
      cnt_q <= '0;
      req_q <= out_of_band;
    end else begin
      win_q <= win_q + 1'b1;
      cnt_q <= cnt_inc;
    end
  end

  assign req = req_q;

  assert_stopped_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !req_q);

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !at_end) |=> $stable(req_q));

  assert_inverted_bounds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && at_end && (lo_bound >= hi_bound)) |=> req_q);

  assert_count_saturates_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !at_end && (cnt_q == CNT_FULL)) |=> (cnt_q == CNT_FULL));
endmodule

// File: rtl/clk_freq_guard.sv
module clk_freq_guard
  import cfm_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 8,
  parameter int WIN_LEN = 256,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] PROT_OFS = 8'h00,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h04,
  parameter logic [ADDR_W-1:0] LO_OFS   = 8'h10,
  parameter logic [ADDR_W-1:0] HI_OFS   = 8'h20,
  parameter logic [CNT_W-1:0]  LO_RST   = 8'hA5,
  parameter logic [CNT_W-1:0]  HI_RST   = 8'hC9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mon_clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              freq_rst_req
);
  localparam int USED_W = (CNT_W > CODE_W) ? CNT_W : CODE_W;

  logic [CNT_W-1:0] lo_bound;
  logic [CNT_W-1:0] hi_bound;
  logic             run;
  logic             edge_pulse;
  logic [DATA_W-USED_W-1:0] unused_wdata_hi;

  assign unused_wdata_hi = wdata[DATA_W-1:USED_W];

  cfm_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .PROT_OFS(PROT_OFS), .CTRL_OFS(CTRL_OFS), .LO_OFS(LO_OFS), .HI_OFS(HI_OFS),
    .LO_RST(LO_RST), .HI_RST(HI_RST)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wr_key(wdata[CODE_W-1:0]), .wr_bound(wdata[CNT_W-1:0]),
    .rdata(rdata), .lo_bound(lo_bound), .hi_bound(hi_bound), .run(run)
  );

  cfm_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .mon_clk(mon_clk), .clk(clk), .rst_n(rst_n), .edge_pulse(edge_pulse)
  );

  cfm_window #(.CNT_W(CNT_W), .WIN_LEN(WIN_LEN)) win_i (
    .clk(clk), .rst_n(rst_n), .run(run), .edge_pulse(edge_pulse),
    .lo_bound(lo_bound), .hi_bound(hi_bound), .req(freq_rst_req)
  );
endmodule

// File: tb/clk_freq_guard_tb_top.sv
`timescale 1ns/1ps
module clk_freq_guard_tb_top;
  localparam int WIN = 600;
  localparam int WAIT3 = 3 * WIN + 50;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mon_clk = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        freq_rst_req;

  int checks = 0;
  int failures = 0;
  int mon_half = 0;
  int mon_total = 0;
  bit finished = 1'b0;

  // reference model state
  bit      m_lock, m_run, m_req;
  int      m_lo, m_hi, m_win, m_cnt;
  int      hist[$];

  clk_freq_guard #(.WIN_LEN(WIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .mon_clk(mon_clk), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .freq_rst_req(freq_rst_req)
  );

  always #10 clk = ~clk;

  // monitored clock on a grid offset by 5 ns from every reference edge
  initial begin
    #5;
    forever begin
      if (mon_half == 0) #10;
      else begin
        #(mon_half) mon_clk = ~mon_clk;
      end
    end
  end

  always @(posedge mon_clk) if (rst_n) mon_total++;

  function automatic int exp_rd(input logic [7:0] a);
    case (a)
      8'h00: return m_lock ? 32'h06 : 0;
      8'h04: return m_run ? 32'hE4 : 0;
      8'h10: return m_lo;
      8'h20: return m_hi;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lock = 0; m_run = 0; m_req = 0;
      m_lo = 'hA5; m_hi = 'hC9; m_win = 0; m_cnt = 0;
      hist = {0, 0, 0, 0};
    end else begin
      bit old_lock, old_run;
      int old_lo, old_hi, inc, c;
      old_lock = m_lock; old_run = m_run; old_lo = m_lo; old_hi = m_hi;
      hist.push_back(mon_total);
      while (hist.size() > 4) void'(hist.pop_front());
      inc = hist[1] - hist[0];
      if (wr_en) begin
        case (addr)
          8'h00: m_lock = (wdata[7:0] == 8'h06);
          8'h04: m_run  = (wdata[7:0] == 8'hE4);
          8'h10: if (!old_lock && !old_run) m_lo = wdata[7:0];
          8'h20: if (!old_lock && !old_run) m_hi = wdata[7:0];
          default: ;
        endcase
      end
      if (!old_run) begin
        m_win = 0; m_cnt = 0; m_req = 0;
      end else begin
        c = m_cnt + inc;
        if (c > 255) c = 255;
        if (m_win == WIN - 1) begin
          m_req = (old_lo >= old_hi) || (c < old_lo) || (c > old_hi);
          m_win = 0; m_cnt = 0;
        end else begin
          m_win++; m_cnt = c;
        end
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks += 2;
      if (rdata !== exp_rd(addr)) begin
        failures++;
        $display("FAIL R2 per-cycle rdata addr=%h actual=%h expected=%h", addr, rdata, exp_rd(addr));
      end
      if (freq_rst_req !== m_req) begin
        failures++;
        $display("FAIL R7 per-cycle request actual=%b expected=%b at %0t", freq_rst_req, m_req, $time);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); #1;
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); #1;
    addr = a;
    @(negedge clk); #2;
    checks++;
    if (rdata !== e) begin
      failures++;
      $display("FAIL %s read addr=%h actual=%h expected=%h", tag, a, rdata, e);
    end
  endtask

  task automatic expect_req(input logic e, input string tag);
    @(negedge clk); #2;
    checks++;
    if (freq_rst_req !== e) begin
      failures++;
      $display("FAIL %s request actual=%b expected=%b", tag, freq_rst_req, e);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    #95 rst_n = 1'b1;
    // R1 reset state
    expect_req(1'b0, "R1");
    expect_rd(8'h10, 32'hA5, "R1");
    expect_rd(8'h20, 32'hC9, "R1");
    expect_rd(8'h00, 32'h00, "R1");
    expect_rd(8'h04, 32'h00, "R1");
    // R2 layout and upper bits
    wr(8'h10, 32'hFFFF_FF20);
    expect_rd(8'h10, 32'h20, "R2");
    wr(8'h20, 32'h0000_0050);
    expect_rd(8'h20, 32'h50, "R2");
    expect_rd(8'h08, 32'h00, "R2");
    // R3 lock and unlock
    wr(8'h00, 32'h06);
    expect_rd(8'h00, 32'h06, "R3");
    wr(8'h10, 32'h77);
    expect_rd(8'h10, 32'h20, "R3");
    wr(8'h00, 32'h00);
    wr(8'h10, 32'h21);
    expect_rd(8'h10, 32'h21, "R3");
    wr(8'h10, 32'h20);
    // R4 running blocks bound writes
    mon_half = 100;
    wr(8'h04, 32'hE4);
    expect_rd(8'h04, 32'hE4, "R4");
    wr(8'h10, 32'h01);
    expect_rd(8'h10, 32'h20, "R4");
    // R5 read while locked and running
    wr(8'h00, 32'h06);
    expect_rd(8'h10, 32'h20, "R5");
    expect_rd(8'h20, 32'h50, "R5");
    // R7 about 60 edges per window, inside 0x20..0x50
    repeat (WAIT3) @(negedge clk);
    expect_req(1'b0, "R7");
    // R7 about 200 edges, above the band
    mon_half = 30;
    repeat (WAIT3) @(negedge clk);
    expect_req(1'b1, "R7");
    // R7 stopped clock, below the band
    mon_half = 0;
    repeat (WAIT3) @(negedge clk);
    expect_req(1'b1, "R7");
    // R9 stopping clears the request
    wr(8'h04, 32'h00);
    expect_req(1'b0, "R9");
    repeat (700) @(negedge clk);
    expect_req(1'b0, "R9");
    // R6 saturation: ~300 edges would wrap to ~44 without it
    wr(8'h00, 32'h00);
    wr(8'h10, 32'hF0);
    wr(8'h20, 32'hFF);
    mon_half = 20;
    wr(8'h04, 32'hE4);
    repeat (WAIT3) @(negedge clk);
    expect_req(1'b0, "R6");
    // R8 equal bounds with matching count of zero
    wr(8'h04, 32'h00);
    mon_half = 0;
    wr(8'h10, 32'h00);
    wr(8'h20, 32'h00);
    repeat (10) @(negedge clk);
    wr(8'h04, 32'hE4);
    repeat (WAIT3) @(negedge clk);
    expect_req(1'b1, "R8");
    // R6 exact position of the first window end
    wr(8'h04, 32'h00);
    wr(8'h10, 32'h01);
    wr(8'h20, 32'hFF);
    wr(8'h04, 32'hE4);
    repeat (WIN - 2) @(negedge clk);
    expect_req(1'b0, "R6");
    expect_req(1'b1, "R6");
    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule